// File: doc/BRIEF.md
# Dual-Mode Systolic Boundary Cell

This block is the diagonal processing element of a triangular systolic array that evaluates CX+D under the constraint AX=B. It keeps a single stored value R and, for every incoming entry X, produces a pair of modification factors (cosine-like and sine-like) that its row neighbours use to update the rest of the data row. A mode input chosen per entry selects what the pair means.

In rotation mode, used while the rows of A and B stream through, the cell forms Givens rotation coefficients from R and X and replaces R with the rotated norm. In elimination mode, used while the rows of C and D stream through, the cell treats R as a frozen pivot and emits the Gaussian elimination multiplier X/R. A zero pivot raises a sticky error flag.

All data are signed 16-bit fixed point with 13 fraction bits (Q2.13, so 8192 stands for 1.0). Square root and division are iterative units that resolve one result bit per cycle. The cell takes one entry at a time: an entry is taken only when the cell is idle and the downstream side is ready. The factor pair is offered until it is taken.

Top module: `givens_gauss_cell`

## Requirements
- R1: After reset or after `clear`, R is 0, `pivot_err` is 0 and `f_valid` is 0; a reset cell shows `x_ready` equal to `f_ready`.
- R2: In rotation mode (`phase_i`=0) with X≠0, the cell forms r' = floor(sqrt(R²+X²)) on the raw integer codes, saturated to 32767. It outputs `f_cos` = floor(R·8192/r') and `f_sin` = sign(X)·floor(|X|·8192/r'), and R becomes r'.
- R3: In rotation mode with X=0 (whatever R is, including 0), the cell outputs `f_cos`=8192 and `f_sin`=0, and R is unchanged.
- R4: In elimination mode (`phase_i`=1) with R≠0, the cell outputs `f_cos`=0 and `f_sin` = sign(X)·min(floor(|X|·8192/R), 32767), and R is unchanged.
- R5: In elimination mode with R=0, the cell outputs `f_cos`=0 and `f_sin`=0 and sets `pivot_err`. The flag stays set through later entries until `clear` or reset.
- R6: `x_ready` is high only when the cell holds no entry and `f_ready` is high. An entry offered while a result is pending is not taken and does not change R.
- R7: While `f_valid` is high and `f_ready` is low, `f_valid`, `f_cos` and `f_sin` hold their values.
- R8: `f_valid` rises no more than 40 cycles after the cycle in which an entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Sets R to 0, clears the error flag, abandons any entry in flight |
| phase_i | input | 1 | Mode for the offered entry: 0 rotation, 1 elimination |
| x_valid | input | 1 | Entry offered |
| x_ready | output | 1 | Entry can be taken |
| x_data | input | 16 | Entry X, signed Q2.13 |
| f_valid | output | 1 | Factor pair available |
| f_ready | input | 1 | Downstream takes the factor pair |
| f_cos | output | 16 | Cosine-like factor, signed Q2.13 |
| f_sin | output | 16 | Sine-like factor, signed Q2.13 |
| pivot_err | output | 1 | Sticky zero-pivot flag |

## Verification
R cannot be seen directly, so a wrong stored value shows up in the factors of the entry after the one that corrupted it. This is one full transaction later, about 35 cycles in rotation mode or 18 in elimination mode. The stimulus chains rotations so that each result depends on every earlier update, and it follows each stall or zero-input case with an entry whose expected output is set by R alone. A handshake fault, such as taking an entry while a result is pending, shows in the same way through the next result. Loss of the hold or of the flag shows at the ports in the cycle it happens.

// File: rtl/ggc_pkg.sv
// Shared definitions for the dual-mode boundary cell.
// Assumes two's-complement fixed point with a parameterised fraction width.
package ggc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROOT = 2'd1,
        ST_DIV  = 2'd2,
        ST_OUT  = 2'd3
    } cell_state_t;
endpackage

// File: rtl/ggc_isqrt.sv
// Iterative integer square root: one result bit per cycle, MSB first.
// Assumes start is ignored while busy; abort returns the unit to idle.
module ggc_isqrt #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           abort,
    input  logic           start,
    input  logic [2*W-1:0] radicand,
    output logic           done,
    output logic [W-1:0]   root
);
    localparam int IW = $clog2(W);

    logic [2*W-1:0] rad_q;
    logic [W-1:0]   root_q;
    logic [IW-1:0]  idx_q;
    logic           busy_q;
    logic           done_q;
    logic [W-1:0]   cand;
    logic [2*W-1:0] cand_sq;

    // Trial root with the current bit set, and its square.
    always_comb begin
        cand    = root_q | (W'(1) << idx_q);
        cand_sq = {{W{1'b0}}, cand} * {{W{1'b0}}, cand};
    end

    // Load on start, then settle one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            rad_q  <= '0;
            root_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rad_q  <= radicand;
                root_q <= '0;
                idx_q  <= IW'(W - 1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cand_sq <= rad_q) root_q <= cand;
                if (idx_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign root = root_q;
endmodule

// File: rtl/ggc_qdiv.sv
// Iterative signed fixed-point divider: quot = num * 2^F / den, truncated
// toward zero, magnitude saturated to the largest positive code.
// Assumes den is nonzero and positive; one quotient bit per cycle.
module ggc_qdiv #(
    parameter int W = 16,
    parameter int F = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic [W-1:0]        den,
    output logic                done,
    output logic signed [W-1:0] quot
);
    localparam int          IW   = $clog2(W);
    localparam logic [W-1:0] QMAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0]   den_q, rem_q, lo_q, q_q, mag, qm;
    logic [IW-1:0]  idx_q;
    logic           busy_q, done_q, neg_q, ovf_q;
    logic [2*W-1:0] dvd;
    logic [W:0]     trial;

    // Operand magnitude and scaled dividend.
    always_comb begin
        mag   = num[W-1] ? (~num + 1'b1) : num;
        dvd   = {{W{1'b0}}, mag} << F;
        trial = {rem_q, lo_q[W-1]};
    end

    // Restoring long division, one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            den_q <= '0; rem_q <= '0; lo_q <= '0; q_q <= '0;
            idx_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
            neg_q <= 1'b0; ovf_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                den_q  <= den;
                neg_q  <= num[W-1];
                ovf_q  <= {{W{1'b0}}, mag} >= ({{W{1'b0}}, den} << (W - F));
                rem_q  <= dvd[2*W-1:W];
                lo_q   <= dvd[W-1:0];
                q_q    <= '0;
                idx_q  <= IW'(W - 1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                lo_q <= lo_q << 1;
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= W'(trial - {1'b0, den_q});
                    q_q   <= {q_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    q_q   <= {q_q[W-2:0], 1'b0};
                end
                if (idx_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // Saturate magnitude, then restore the sign.
    always_comb begin
        qm   = (ovf_q || q_q[W-1]) ? QMAX : q_q;
        quot = neg_q ? -$signed(qm) : $signed(qm);
    end

    assign done = done_q;
endmodule

// File: rtl/givens_gauss_cell.sv
// Boundary cell of a triangular systolic array. Rotation mode: Givens
// coefficients from stored R and entry X, R takes the rotated norm.
// Elimination mode: multiplier X/R with R frozen as pivot.
// Assumes R is never negative (it is only cleared or set to a root).
module givens_gauss_cell
    import ggc_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 phase_i,
    input  logic                 x_valid,
    output logic                 x_ready,
    input  logic signed [DW-1:0] x_data,
    output logic                 f_valid,
    input  logic                 f_ready,
    output logic signed [DW-1:0] f_cos,
    output logic signed [DW-1:0] f_sin,
    output logic                 pivot_err
);
    localparam logic [DW-1:0]        VMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] ONE  = DW'(1) << FW;

    cell_state_t           state_q;
    logic [DW-1:0]         r_q, root_q, root_sat, xmag, sq_root, den_s;
    logic signed [DW-1:0]  x_q, c_q, s_q, num_s, quot_c, quot_s;
    logic                  elim_q, err_q, accept, sq_start, sq_done;
    logic                  dc_start, ds_start, dc_done, ds_done;
    logic [2*DW-1:0]       radicand;

    // Handshake and datapath operand selection.
    always_comb begin
        x_ready  = (state_q == ST_IDLE) && f_ready;
        accept   = x_valid && x_ready;
        xmag     = x_data[DW-1] ? (~x_data + 1'b1) : x_data;
        radicand = ({{DW{1'b0}}, xmag} * {{DW{1'b0}}, xmag})
                 + ({{DW{1'b0}}, r_q} * {{DW{1'b0}}, r_q});
        root_sat = (sq_root > VMAX) ? VMAX : sq_root;
        sq_start = accept && !phase_i && (x_data != '0);
        dc_start = (state_q == ST_ROOT) && sq_done;
        ds_start = dc_start || (accept && phase_i && (r_q != '0));
        den_s    = (state_q == ST_ROOT) ? root_sat : r_q;
        num_s    = (state_q == ST_ROOT) ? x_q : x_data;
    end

    ggc_isqrt #(.W(DW)) u_root (
        .clk(clk), .rst_n(rst_n), .abort(clear), .start(sq_start),
        .radicand(radicand), .done(sq_done), .root(sq_root)
    );

    ggc_qdiv #(.W(DW), .F(FW)) u_div_cos (
        .clk(clk), .rst_n(rst_n), .abort(clear), .start(dc_start),
        .num($signed(r_q)), .den(root_sat), .done(dc_done), .quot(quot_c)
    );

    ggc_qdiv #(.W(DW), .F(FW)) u_div_sin (
        .clk(clk), .rst_n(rst_n), .abort(clear), .start(ds_start),
        .num(num_s), .den(den_s), .done(ds_done), .quot(quot_s)
    );

    // Sequencing, stored value, factor registers and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= ST_IDLE;
            r_q     <= '0;
            root_q  <= '0;
            x_q     <= '0;
            c_q     <= '0;
            s_q     <= '0;
            elim_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    x_q    <= x_data;
                    elim_q <= phase_i;
                    if (!phase_i) begin
                        if (x_data == '0) begin
                            c_q     <= ONE;
                            s_q     <= '0;
                            state_q <= ST_OUT;
                        end else begin
                            state_q <= ST_ROOT;
                        end
                    end else if (r_q == '0) begin
                        err_q   <= 1'b1;
                        c_q     <= '0;
                        s_q     <= '0;
                        state_q <= ST_OUT;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_ROOT: if (sq_done) begin
                    root_q  <= root_sat;
                    state_q <= ST_DIV;
                end
                ST_DIV: if (ds_done) begin
                    c_q     <= elim_q ? '0 : quot_c;
                    s_q     <= quot_s;
                    if (!elim_q) r_q <= root_q;
                    state_q <= ST_OUT;
                end
                ST_OUT: if (f_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign f_valid   = (state_q == ST_OUT);
    assign f_cos     = c_q;
    assign f_sin     = s_q;
    assign pivot_err = err_q;
    // dc_done finishes in the same cycle as ds_done; only the latter is used.
    logic unused_ok;
    assign unused_ok = dc_done;
endmodule

// File: rtl/ggc_chk.sv
// Protocol and mode checks for the boundary cell, bound to the top module.
// Assumes the latency limit covers the rotation path (root plus divide).
module ggc_chk #(
    parameter int DW  = 16,
    parameter int LIM = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          x_valid,
    input logic          x_ready,
    input logic          f_valid,
    input logic          f_ready,
    input logic [DW-1:0] f_cos,
    input logic [DW-1:0] f_sin,
    input logic          pivot_err,
    input logic          elim_q
);
    logic       pend_q;
    logic [7:0] lat_q;

    // Count cycles from an accepted entry to its result.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= 1'b0;
            lat_q  <= '0;
        end else if (x_valid && x_ready) begin
            pend_q <= 1'b1;
            lat_q  <= 8'd1;
        end else if (f_valid) begin
            pend_q <= 1'b0;
        end else if (pend_q && lat_q != 8'hFF) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_clear_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!f_valid && !pivot_err));

    p_elim_cos_zero_r4: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (f_valid && elim_q) |-> (f_cos == '0));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pivot_err && !clear) |=> pivot_err);

    p_no_take_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> !x_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (f_valid && !f_ready) |=> (f_valid && $stable(f_cos) && $stable(f_sin)));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n || clear)
        pend_q |-> (lat_q <= 8'(LIM)));
endmodule

bind givens_gauss_cell ggc_chk #(.DW(DW), .LIM(40)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .x_valid(x_valid),
    .x_ready(x_ready), .f_valid(f_valid), .f_ready(f_ready),
    .f_cos(f_cos), .f_sin(f_sin), .pivot_err(pivot_err), .elim_q(elim_q)
);

// File: tb/givens_gauss_cell_tb_top.sv
`timescale 1ns/1ps
// Bench for the boundary cell: a chained vector table, then directed cases.
module givens_gauss_cell_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic phase_i = 1'b0;
    logic x_valid = 1'b0;
    logic f_ready = 1'b1;
    logic signed [15:0] x_data = '0;
    logic x_ready, f_valid, pivot_err;
    logic signed [15:0] f_cos, f_sin;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    givens_gauss_cell dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .phase_i(phase_i),
        .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
        .f_valid(f_valid), .f_ready(f_ready), .f_cos(f_cos), .f_sin(f_sin),
        .pivot_err(pivot_err)
    );

    // {mode, X, expected cos, expected sin}; chained from R = 0.
    localparam logic [48:0] VEC [7] = '{
        {1'b0,  16'sd8192,   16'sd0,    16'sd8192},
        {1'b0,  16'sd0,      16'sd8192, 16'sd0},
        {1'b0,  16'sd8192,   16'sd5792, 16'sd5792},
        {1'b0, -16'sd11585,  16'sd5792, -16'sd5792},
        {1'b1,  16'sd8191,   16'sd0,    16'sd4095},
        {1'b1, -16'sd16383,  16'sd0,    -16'sd8192},
        {1'b1,  16'sd32767,  16'sd0,    16'sd16384}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    // Offer one entry, wait for its pair; optionally stall the output.
    task automatic run_op(input logic ph, input logic signed [15:0] x,
                          input bit stall,
                          output logic signed [15:0] c,
                          output logic signed [15:0] s);
        int n;
        int lat;
        @(negedge clk);
        f_ready = 1'b1; phase_i = ph; x_data = x; x_valid = 1'b1;
        n = 0;
        while (!x_ready && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        x_valid = 1'b0;
        if (stall) f_ready = 1'b0;
        lat = 1;
        while (!f_valid && lat < 100) begin @(negedge clk); lat++; end
        check("R8 latency within 40", int'(lat <= 40), 1);
        c = f_cos; s = f_sin;
        if (stall) begin
            phase_i = 1'b0; x_data = 16'sd1000; x_valid = 1'b1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check("R7 valid held", int'(f_valid), 1);
                check("R7 cos held", int'(f_cos), int'(c));
                check("R7 sin held", int'(f_sin), int'(s));
                check("R6 not ready while pending", int'(x_ready), 0);
            end
            x_valid = 1'b0;
            f_ready = 1'b1;
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] c, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset f_valid", int'(f_valid), 0);
        check("R1 reset x_ready", int'(x_ready), 1);
        check("R1 reset pivot_err", int'(pivot_err), 0);

        // R2 R3 R4: chained table, each result depends on earlier R updates
        for (int i = 0; i < 7; i++) begin
            run_op(VEC[i][48], VEC[i][47:32], 1'b0, c, s);
            check($sformatf("R2/R3/R4 vec %0d cos", i), int'(c),
                  int'($signed(VEC[i][31:16])));
            check($sformatf("R2/R3/R4 vec %0d sin", i), int'(s),
                  int'($signed(VEC[i][15:0])));
        end

        // R1: clear zeroes R; R3: zero entry with R = 0
        do_clear();
        run_op(1'b0, 16'sd0, 1'b0, c, s);
        check("R3 zero entry cos", int'(c), 8192);
        check("R3 zero entry sin", int'(s), 0);

        // R5: zero pivot, then stickiness
        run_op(1'b1, 16'sd100, 1'b0, c, s);
        check("R5 zero pivot sin", int'(s), 0);
        check("R5 zero pivot cos", int'(c), 0);
        check("R5 flag set", int'(pivot_err), 1);
        run_op(1'b1, -16'sd50, 1'b0, c, s);
        check("R5 flag sticky", int'(pivot_err), 1);
        check("R5 second zero pivot sin", int'(s), 0);
        do_clear();
        check("R1 clear drops flag", int'(pivot_err), 0);

        // R2: rotation from R = 0 gives pure sine
        run_op(1'b0, 16'sd5, 1'b0, c, s);
        check("R2 from zero cos", int'(c), 0);
        check("R2 from zero sin", int'(s), 8192);

        // R4: saturation both signs with R = 5
        run_op(1'b1, 16'sd32767, 1'b0, c, s);
        check("R4 positive saturation", int'(s), 32767);
        run_op(1'b1, -16'sd32768, 1'b0, c, s);
        check("R4 negative saturation", int'(s), -32767);

        // R2: norm saturates to 32767 (R = 5, X = -32768)
        run_op(1'b0, -16'sd32768, 1'b0, c, s);
        check("R2 saturated norm cos", int'(c), 1);
        check("R2 saturated norm sin", int'(s), -8192);
        run_op(1'b1, 16'sd32767, 1'b0, c, s);
        check("R2 stored norm is 32767", int'(s), 8192);

        // R6 R7: stalled output with a competing entry offered
        run_op(1'b1, -16'sd16384, 1'b1, c, s);
        check("R7 stalled result cos", int'(c), 0);
        check("R7 stalled result sin", int'(s), -4096);
        run_op(1'b1, 16'sd32767, 1'b0, c, s);
        check("R6 offered entry ignored, R kept", int'(s), 8192);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule